// File: doc/BRIEF.md
# Half-Duplex Infrared Turnaround Guard

This block sits beside a serial transmitter/receiver pair that shares one infrared medium. When half-duplex operation is on, it makes sure that a quiet interval passes each time the link changes direction. After the last bit of an outgoing character, it masks the receive path until a programmable interval has elapsed. That stops the receiver from seeing the echo of its own transmitter. After the last bit of an incoming character, it withdraws permission to transmit until the same interval has elapsed.

The interval is set in units of 100 us, from 0 to 100 units (0 to 10 ms). A prescaler turns the system clock into a 100 us step, and a step counter measures the interval. The setting is captured at the moment each interval starts. Follow-on activity restarts the interval. A new outgoing character sent during a transmit interval restarts it once that character ends. A start bit received during a receive interval restarts it once that character ends. A transmit request that arrives while a character is being received waits until the interval after that character has run out.

Top module: `ir_turnaround_ctrl`

## Requirements
- R1: With half-duplex on, from the cycle after `tx_busy` is seen in the idle state until the last-bit strobe, `rx_enable` is 0 and `tx_permit` is 1. If `tx_busy` and `rx_start` both arrive in the idle state in the same cycle, transmission wins.
- R2: For a setting N in 1..100, `rx_enable` stays 0 for exactly N x TICK_CYCLES clock cycles after the edge that samples `tx_last_bit`, and is 1 on the cycle after that.
- R3: If `tx_busy` is raised during a transmit interval, the block returns to transmitting. A full interval is then measured again from the next `tx_last_bit`, and `rx_enable` stays 0 throughout.
- R4: During a transmit interval, each cycle in which `tx_pending` is high freezes the interval, which lengthens the receive mask by that many cycles.
- R5: Settings above 100 are treated as 100. The setting is captured when an interval starts, and changes made later have no effect on that interval.
- R6: With half-duplex on, `tx_permit` is 0 while a character is being received (from `rx_start` to `rx_last_bit`). It stays 0 for exactly N x TICK_CYCLES cycles after the edge that samples `rx_last_bit`.
- R7: An `rx_start` during a receive interval puts the block back into reception. `tx_permit` then stays 0 until a full interval has passed after the following `rx_last_bit`.
- R8: A setting of 0 gives no interval: the output that was held off is 1 on the cycle right after the last-bit strobe.
- R9: With half-duplex off, `rx_enable` and `tx_permit` are both 1 whatever the strobes do. Turning half-duplex off during an interval ends the interval at once.
- R10: An `rx_start` during a transmit interval is ignored: `tx_permit` stays 1 and the interval length does not change.
- R11: After synchronous reset, both outputs are 1 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hdx_en | input | 1 | Half-duplex turnaround enable |
| gap_setting | input | SETW | Interval in 100 us units, clamped to 100 |
| tx_busy | input | 1 | Transmitter is sending a character (level) |
| tx_last_bit | input | 1 | One-cycle strobe at the last transmitted bit |
| tx_pending | input | 1 | Transmit buffer holds data waiting to be sent |
| rx_start | input | 1 | One-cycle strobe on a received start bit |
| rx_last_bit | input | 1 | One-cycle strobe at the last received bit |
| rx_enable | output | 1 | Receive path unmasked |
| tx_permit | output | 1 | Transmission allowed to start |

## Verification
The interval length is swept over settings 0 to 12 and several large and over-range values, once for each direction. Measuring in both directions separates the transmit-side mask from the receive-side hold-off, and the over-range values show the clamp. Restart patterns separate the three restart rules: a fresh outgoing character, a pending-data hold, and a start bit in either interval. Each one gives a different total mask length that can be predicted. Changing the setting mid-interval, dropping the enable mid-interval, and arbitrating simultaneous requests each show that the captured value, the bypass, or the priority is what drives the outputs.

// File: rtl/ir_ta_pkg.sv
package ir_ta_pkg;

    typedef enum logic [2:0] {
        DIR_IDLE,
        DIR_TX,
        DIR_TX_GAP,
        DIR_RX,
        DIR_RX_GAP
    } dir_state_e;

    typedef struct packed {
        logic tx_busy;
        logic tx_last;
        logic tx_pending;
        logic rx_start;
        logic rx_last;
    } link_evt_t;

    function automatic int unsigned clamp_steps(input int unsigned raw,
                                                input int unsigned limit);
        return (raw > limit) ? limit : raw;
    endfunction

    function automatic int unsigned cycles_per_step(input int unsigned clk_hz,
                                                    input int unsigned step_us);
        int unsigned c;
        c = ((clk_hz / 1000) * step_us) / 1000;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/ir_ta_tick.sv
module ir_ta_tick #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

    generate
        if (DIV > 1) begin : g_sparse
            p_tick_sparse_r2: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/ir_ta_gap_timer.sv
module ir_ta_gap_timer #(
    parameter int unsigned MAX_STEPS = 100,
    parameter int unsigned SW        = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [SW-1:0] load_steps,
    input  logic          tick,
    output logic          done
);
    logic [SW-1:0] remain_q;

    assign done = tick && (remain_q == SW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_steps;
        end else if (tick && remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // R5: count never exceeds the clamped limit
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        remain_q <= SW'(MAX_STEPS));

    // R4: without a step pulse the remaining count holds
    p_hold_freeze_r4: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(remain_q));

endmodule

// File: rtl/ir_ta_dir_fsm.sv
module ir_ta_dir_fsm
    import ir_ta_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hdx_en,
    input  link_evt_t  evt,
    input  logic       gap_zero,
    input  logic       gap_done,
    output dir_state_e state,
    output logic       load_gap,
    output logic       run_gap
);
    dir_state_e state_q, state_d;

    assign state = state_q;

    assign load_gap = hdx_en &&
                      ((state_q == DIR_TX && evt.tx_last) ||
                       (state_q == DIR_RX && evt.rx_last));

    assign run_gap = (state_q == DIR_TX_GAP && !evt.tx_pending && !evt.tx_busy) ||
                     (state_q == DIR_RX_GAP && !evt.rx_start);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIR_IDLE: begin
                if (evt.tx_busy)       state_d = DIR_TX;
                else if (evt.rx_start) state_d = DIR_RX;
            end
            DIR_TX: begin
                if (evt.tx_last) state_d = gap_zero ? DIR_IDLE : DIR_TX_GAP;
            end
            DIR_TX_GAP: begin
                if (evt.tx_busy)   state_d = DIR_TX;
                else if (gap_done) state_d = DIR_IDLE;
            end
            DIR_RX: begin
                if (evt.rx_last) state_d = gap_zero ? DIR_IDLE : DIR_RX_GAP;
            end
            DIR_RX_GAP: begin
                if (evt.rx_start)  state_d = DIR_RX;
                else if (gap_done) state_d = DIR_IDLE;
            end
            default: state_d = DIR_IDLE;
        endcase
        if (!hdx_en) state_d = DIR_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= DIR_IDLE;
        else     state_q <= state_d;
    end

    // R9: disabling half-duplex returns to idle
    p_off_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !hdx_en |=> state_q == DIR_IDLE);

    // R2: last transmit bit with a nonzero setting opens the interval
    p_gap_entry_r2: assert property (@(posedge clk) disable iff (rst)
        (hdx_en && state_q == DIR_TX && evt.tx_last && !gap_zero) |=> state_q == DIR_TX_GAP);

    // R7: start bit in receive interval goes back to reception
    p_rx_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (hdx_en && state_q == DIR_RX_GAP && evt.rx_start) |=> state_q == DIR_RX);

endmodule

// File: rtl/ir_turnaround_ctrl.sv
module ir_turnaround_ctrl
    import ir_ta_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ = 125_000_000,
    parameter int unsigned STEP_US     = 100,
    parameter int unsigned MAX_STEPS   = 100,
    parameter int unsigned SETW        = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hdx_en,
    input  logic [SETW-1:0] gap_setting,
    input  logic            tx_busy,
    input  logic            tx_last_bit,
    input  logic            tx_pending,
    input  logic            rx_start,
    input  logic            rx_last_bit,
    output logic            rx_enable,
    output logic            tx_permit
);
    localparam int unsigned TICK_CYCLES = cycles_per_step(CLK_FREQ_HZ, STEP_US);
    localparam int unsigned SW          = $clog2(MAX_STEPS + 1);

    link_evt_t  evt;
    dir_state_e state;
    logic [SW-1:0] steps;
    logic load_gap, run_gap, tick, gap_done, gap_zero;

    assign evt = '{tx_busy:    tx_busy,
                   tx_last:    tx_last_bit,
                   tx_pending: tx_pending,
                   rx_start:   rx_start,
                   rx_last:    rx_last_bit};

    assign steps    = SW'(clamp_steps(int'(gap_setting), MAX_STEPS));
    assign gap_zero = (steps == '0);

    ir_ta_dir_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .hdx_en   (hdx_en),
        .evt      (evt),
        .gap_zero (gap_zero),
        .gap_done (gap_done),
        .state    (state),
        .load_gap (load_gap),
        .run_gap  (run_gap)
    );

    ir_ta_tick #(.DIV(TICK_CYCLES)) u_tick (
        .clk   (clk),
        .rst   (rst),
        .clear (load_gap),
        .run   (run_gap),
        .tick  (tick)
    );

    ir_ta_gap_timer #(.MAX_STEPS(MAX_STEPS), .SW(SW)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load       (load_gap),
        .load_steps (steps),
        .tick       (tick),
        .done       (gap_done)
    );

    assign rx_enable = !hdx_en || !(state == DIR_TX || state == DIR_TX_GAP);
    assign tx_permit = !hdx_en || !(state == DIR_RX || state == DIR_RX_GAP);

    // R1: the two directions are never both shut
    p_one_dir_r1: assert property (@(posedge clk) disable iff (rst)
        rx_enable || tx_permit);

    // R10: a start bit in the transmit interval leaves transmission permitted
    p_rx_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (hdx_en && !rx_enable && rx_start) |=> tx_permit);

endmodule

// File: tb/ir_turnaround_ctrl_bench.sv
module ir_turnaround_ctrl_bench;
    localparam int unsigned CLK_HZ = 40_000;
    localparam int DIV = 4;

    logic clk = 0, rst = 1, hdx_en = 1;
    logic [7:0] gap_setting = 0;
    logic tx_busy = 0, tx_last_bit = 0, tx_pending = 0, rx_start = 0, rx_last_bit = 0;
    logic rx_enable, tx_permit;
    int checks = 0, fails = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ir_turnaround_ctrl #(.CLK_FREQ_HZ(CLK_HZ)) u_ir_turnaround_ctrl (
        .clk(clk), .rst(rst), .hdx_en(hdx_en), .gap_setting(gap_setting),
        .tx_busy(tx_busy), .tx_last_bit(tx_last_bit), .tx_pending(tx_pending),
        .rx_start(rx_start), .rx_last_bit(rx_last_bit),
        .rx_enable(rx_enable), .tx_permit(tx_permit));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int s);
        return ((s > 100) ? 100 : s) * DIV;
    endfunction

    task automatic tx_frame(input int bits);
        @(negedge clk); tx_busy = 1;
        repeat (bits) @(negedge clk);
        check(!rx_enable && tx_permit, "R1", {rx_enable, tx_permit}, 1);
        tx_last_bit = 1;
        @(negedge clk); tx_last_bit = 0; tx_busy = 0;
    endtask

    task automatic rx_frame(input int bits);
        @(negedge clk); rx_start = 1;
        @(negedge clk); rx_start = 0;
        repeat (bits) @(negedge clk);
        check(!tx_permit && rx_enable, "R6", {rx_enable, tx_permit}, 2);
        rx_last_bit = 1;
        @(negedge clk); rx_last_bit = 0;
    endtask

    task automatic count_rx_low(inout int n);
        while (!rx_enable && n < 2000) begin n++; @(negedge clk); end
    endtask

    task automatic count_tx_low(inout int n);
        while (!tx_permit && n < 2000) begin n++; @(negedge clk); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int settings[19] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,50,99,100,101,200,255};
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(rx_enable && tx_permit, "R11", {rx_enable, tx_permit}, 3);

        // R2 R5 R8: transmit-side sweep
        foreach (settings[i]) begin
            gap_setting = 8'(settings[i]);
            tx_frame(3);
            n = 0; count_rx_low(n);
            check(n == exp_len(settings[i]),
                  settings[i] == 0 ? "R8" : (settings[i] > 100 ? "R5" : "R2"),
                  n, exp_len(settings[i]));
        end

        // R6 R5 R8: receive-side sweep
        foreach (settings[i]) begin
            gap_setting = 8'(settings[i]);
            rx_frame(2);
            n = 0; count_tx_low(n);
            check(n == exp_len(settings[i]),
                  settings[i] == 0 ? "R8" : (settings[i] > 100 ? "R5" : "R6"),
                  n, exp_len(settings[i]));
        end

        // R1: simultaneous requests in idle, transmit wins
        gap_setting = 2;
        @(negedge clk); tx_busy = 1; rx_start = 1;
        @(negedge clk); rx_start = 0;
        check(!rx_enable && tx_permit, "R1", {rx_enable, tx_permit}, 1);
        tx_last_bit = 1;
        @(negedge clk); tx_last_bit = 0; tx_busy = 0;
        n = 0; count_rx_low(n);
        check(n == 8, "R1", n, 8);

        // R3: new character during transmit interval
        gap_setting = 5;
        tx_frame(2);
        repeat (7) @(negedge clk);
        check(!rx_enable, "R3", rx_enable, 0);
        tx_frame(2);
        n = 0; count_rx_low(n);
        check(n == 20, "R3", n, 20);

        // R4: pending data freezes the interval
        gap_setting = 3;
        tx_frame(2);
        tx_pending = 1;
        repeat (6) @(negedge clk);
        tx_pending = 0;
        check(!rx_enable, "R4", rx_enable, 0);
        n = 6; count_rx_low(n);
        check(n == 18, "R4", n, 18);

        // R5: setting captured at interval start
        gap_setting = 4;
        tx_frame(2);
        gap_setting = 100;
        n = 0; count_rx_low(n);
        check(n == 16, "R5", n, 16);

        // R7: start bit during receive interval
        gap_setting = 5;
        rx_frame(2);
        repeat (9) @(negedge clk);
        rx_frame(3);
        n = 0; count_tx_low(n);
        check(n == 20, "R7", n, 20);

        // R10: start bit during transmit interval ignored
        gap_setting = 5;
        tx_frame(2);
        n = 0;
        repeat (3) begin if (!rx_enable) n++; @(negedge clk); end
        rx_start = 1;
        if (!rx_enable) n++;
        @(negedge clk); rx_start = 0;
        check(tx_permit, "R10", tx_permit, 1);
        count_rx_low(n);
        check(n == 20, "R10", n, 20);
        check(tx_permit, "R10", tx_permit, 1);

        // R9: half-duplex off
        hdx_en = 0;
        @(negedge clk); tx_busy = 1;
        @(negedge clk);
        check(rx_enable && tx_permit, "R9", {rx_enable, tx_permit}, 3);
        tx_last_bit = 1;
        @(negedge clk); tx_last_bit = 0; tx_busy = 0;
        check(rx_enable && tx_permit, "R9", {rx_enable, tx_permit}, 3);
        rx_start = 1;
        @(negedge clk); rx_start = 0;
        check(rx_enable && tx_permit, "R9", {rx_enable, tx_permit}, 3);
        hdx_en = 1;
        gap_setting = 10;
        tx_frame(2);
        repeat (5) @(negedge clk);
        check(!rx_enable, "R2", rx_enable, 0);
        hdx_en = 0;
        @(negedge clk);
        check(rx_enable && tx_permit, "R9", {rx_enable, tx_permit}, 3);
        hdx_en = 1;
        @(negedge clk);
        check(rx_enable && tx_permit, "R9", {rx_enable, tx_permit}, 3);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule